// File: doc/BRIEF.md
# Reloadable Frequency Output Generator

This block derives a programmable square or pulse wave from the system clock. A 6-bit down counter runs continuously; whenever it sits at zero it reloads from a programmed reload value on the next clock. That reload event, called an underflow below, marks the end of each reload period of `R+1` clocks, where `R` is the reload value.

The output can be taken from either of two sources. The first is a toggle latch that inverts on every underflow and gives a 50% duty cycle at a period of `2*(R+1)` clocks. The second is the counter itself, which gives a one-clock pulse every `R+1` clocks. An enable field decides whether the pin is driven with the generated wave, or released with the output-enable low so that the pin can serve as ordinary I/O.

Software writes a 16-bit control word. The fields land in a shadow copy and move into the working copy only at the next underflow, so a period that is already running always completes.

Top module: `fog_freq_out`

## Requirements
- R1: While reset is low and after it is released, `fout` and `fout_oe` are 0, and the counter and the toggle latch start from 0.
- R2: In the control word, bits 13..8 hold the reload value `R`, bit 14 selects the source (0 = toggle latch, 1 = counter) and bit 15 is the enable. Bits 7..0 have no effect on the outputs.
- R3: The counter decrements by one per clock while it is non-zero. In the clock after it reads zero, it holds the reload value that was pending, so each reload period lasts `R+1` clocks.
- R4: With source 0 and the enable set, `fout` inverts once per underflow. It has a period of `2*(R+1)` clocks and a high time of `R+1` clocks.
- R5: With source 1 and the enable set, `fout` is high exactly while the counter is zero. This gives a period of `R+1` clocks with one clock high.
- R6: With `R` = 0 the counter underflows every clock. Source 0 then gives a period of 2 clocks, and source 1 holds `fout` high.
- R7: A control write takes effect at the first underflow that follows the write. A write in the same clock as an underflow waits for the next underflow.
- R8: While the working enable is 0, `fout` and `fout_oe` are both 0. While it is 1, `fout_oe` is 1.
- R9: The reload value, the source and the enable all switch together at the same underflow. Between underflows the working configuration does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 16 | Control word written when `ctl_wr` is high |
| fout | output | 1 | Generated frequency, low when disabled |
| fout_oe | output | 1 | Pin drive enable |

## Verification
The bench builds the block with its default parameters: a 6-bit reload field and a 16-bit control word. With these defaults, every reload value from 0 up to long periods of about 20 clocks can be reached within a short run. The bench covers both sources, a reload value of zero, and writes that land mid-period or exactly on an underflow. A behavioural model tracks the shadow and working configuration, so every clock is compared, including the transition period after each write.

// File: rtl/fog_pkg.sv
// Shared constants and types for the frequency output generator.
// Assumes a single control word with fixed field positions.
package fog_pkg;
    parameter int FOG_RL_W   = 6;
    parameter int FOG_CTL_W  = 16;
    parameter int FOG_RL_LSB = 8;
    parameter int FOG_SEL_B  = 14;
    parameter int FOG_EN_B   = 15;

    typedef struct packed {
        logic                en;
        logic                sel;
        logic [FOG_RL_W-1:0] rl;
    } fog_cfg_t;
endpackage

// File: rtl/fog_cfg_stage.sv
// Holds the control fields in two copies.
// The shadow copy takes every write; the working copy loads from the shadow
// only on an underflow. Assumes uf_i comes from a registered counter.
module fog_cfg_stage
    import fog_pkg::*;
#(
    parameter int CTL_W = FOG_CTL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             uf_i,
    output fog_cfg_t         shadow_o,
    output fog_cfg_t         active_o
);
    localparam int RL_MSB = FOG_RL_LSB + FOG_RL_W - 1;

    fog_cfg_t wr_cfg;
    logic     ctl_unused;

    // extract the fields from the written word; low bits are dropped
    always_comb begin
        wr_cfg.en  = wdata_i[FOG_EN_B];
        wr_cfg.sel = wdata_i[FOG_SEL_B];
        wr_cfg.rl  = wdata_i[RL_MSB:FOG_RL_LSB];
    end
    assign ctl_unused = ^wdata_i[FOG_RL_LSB-1:0];

    // shadow copy captures every write
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_o <= '0;
        else if (wr_i) shadow_o <= wr_cfg;
    end

    // working copy follows the shadow only on an underflow
    always_ff @(posedge clk) begin
        if (!rst_n)    active_o <= '0;
        else if (uf_i) active_o <= shadow_o;
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uf_i |=> $stable(active_o));
endmodule

// File: rtl/fog_down_counter.sv
// Free-running down counter.
// It decrements while non-zero; at zero it flags an underflow and loads the
// reload value on the next clock. Assumes reload_i is stable-registered.
module fog_down_counter #(
    parameter int W = fog_pkg::FOG_RL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         uf_o
);
    // underflow is the zero state of the counter
    assign uf_o = (cnt_o == '0);

    // count down, reload on underflow
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_o <= '0;
        else if (uf_o) cnt_o <= reload_i;
        else           cnt_o <= cnt_o - 1'b1;
    end

    // R3
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0) |=> (cnt_o == $past(reload_i)));
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));
endmodule

// File: rtl/fog_out_stage.sv
// Toggle latch and output selection.
// The latch inverts on every underflow. The output is gated by the working
// enable, so the pin is low whenever the generator is disabled.
module fog_out_stage
    import fog_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     uf_i,
    input  fog_cfg_t active_i,
    output logic     fout_o,
    output logic     oe_o
);
    logic tgl_q;

    // toggle latch flips once per underflow
    always_ff @(posedge clk) begin
        if (!rst_n)    tgl_q <= 1'b0;
        else if (uf_i) tgl_q <= ~tgl_q;
    end

    // choose the source and gate it with the enable
    always_comb begin
        oe_o   = active_i.en;
        fout_o = active_i.en & (active_i.sel ? uf_i : tgl_q);
    end

    // R4
    tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_i |=> (tgl_q != $past(tgl_q)));
    // R4
    tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uf_i |=> $stable(tgl_q));
endmodule

// File: rtl/fog_freq_out.sv
// Top level of the reloadable frequency output generator.
// It connects the configuration stage, the down counter and the output stage.
// Assumes a single clock domain with a synchronous active-low reset.
module fog_freq_out
    import fog_pkg::*;
#(
    parameter int CTL_W = FOG_CTL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic             fout,
    output logic             fout_oe
);
    fog_cfg_t              shadow_cfg;
    fog_cfg_t              active_cfg;
    logic [FOG_RL_W-1:0]   cnt;
    logic                  uf;

    fog_cfg_stage #(.CTL_W(CTL_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ctl_wr),
        .wdata_i  (ctl_wdata),
        .uf_i     (uf),
        .shadow_o (shadow_cfg),
        .active_o (active_cfg)
    );

    fog_down_counter #(.W(FOG_RL_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (shadow_cfg.rl),
        .cnt_o    (cnt),
        .uf_o     (uf)
    );

    fog_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .uf_i     (uf),
        .active_i (active_cfg),
        .fout_o   (fout),
        .oe_o     (fout_oe)
    );

    // R9
    cfg_rl_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> (cnt == active_cfg.rl));
endmodule

// File: tb/fog_freq_out_tb.sv
module fog_freq_out_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        fout, fout_oe;

    int checks = 0;
    int failures = 0;

    // behavioural model state
    int m_cnt = 0;
    bit m_tgl = 0;
    int s_rl = 0, a_rl = 0;
    bit s_sel = 0, a_sel = 0, s_en = 0, a_en = 0;

    always #2.5 clk = ~clk;

    fog_freq_out u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .fout(fout), .fout_oe(fout_oe)
    );

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] word(input bit en, input bit sel, input int rl, input logic [7:0] junk);
        return {en, sel, rl[5:0], junk};
    endfunction

    // at a negedge: compare outputs with the model, drive inputs, advance one clock
    task automatic step(input bit wr, input logic [15:0] d, input string tag);
        bit exp_f;
        exp_f = a_en && (a_sel ? (m_cnt == 0) : m_tgl);
        chk(tag, fout, exp_f);
        chk(tag, fout_oe, a_en);
        ctl_wr = wr;
        ctl_wdata = d;
        if (m_cnt == 0) begin
            m_cnt = s_rl; a_rl = s_rl; a_sel = s_sel; a_en = s_en;
            m_tgl = !m_tgl;
        end else begin
            m_cnt = m_cnt - 1;
        end
        if (wr) begin
            s_en = d[15]; s_sel = d[14]; s_rl = int'(d[13:8]);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, ctl_wdata, tag);
    endtask

    task automatic measure(input string tag, input int exp_per, input int exp_hi);
        bit p;
        int per, hi;
        do begin p = fout; step(0, ctl_wdata, tag); end while (!(p == 0 && fout == 1));
        per = 0; hi = 0;
        do begin
            if (fout) hi++;
            per++;
            p = fout;
            step(0, ctl_wdata, tag);
        end while (!(p == 0 && fout == 1));
        chk_int({tag, " period"}, per, exp_per);
        chk_int({tag, " high"}, hi, exp_hi);
    endtask

    initial begin
        int hi_cnt;
        // R1: outputs low during reset
        repeat (3) @(negedge clk);
        chk("R1 reset fout", fout, 1'b0);
        chk("R1 reset oe", fout_oe, 1'b0);
        rst_n = 1'b1;
        idle(4, "R1");

        // R2 / R4: toggle source, R=5, junk in low bits
        step(1, word(1, 0, 5, 8'hA7), "R2");
        idle(30, "R2");
        measure("R4 toggle R=5", 12, 6);

        // R5: counter source, R=3
        step(1, word(1, 1, 3, 8'h5C), "R5");
        idle(20, "R5");
        measure("R5 counter R=3", 4, 1);

        // R6: reload zero, toggle source
        step(1, word(1, 0, 0, 8'hFF), "R6");
        idle(10, "R6");
        measure("R6 toggle R=0", 2, 1);

        // R6: reload zero, counter source holds high
        step(1, word(1, 1, 0, 8'h00), "R6");
        idle(5, "R6");
        hi_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            if (fout) hi_cnt++;
            step(0, ctl_wdata, "R6");
        end
        chk_int("R6 counter R=0 high cycles", hi_cnt, 10);

        // R7: long period, then mid-period write
        step(1, word(1, 0, 20, 8'h00), "R7");
        idle(50, "R7");
        idle(7, "R7");
        step(1, word(1, 0, 2, 8'h00), "R7 mid-period write");
        idle(40, "R7");
        measure("R7 after mid write", 6, 3);

        // R7: write exactly on an underflow waits one period
        step(1, word(1, 0, 9, 8'h00), "R7");
        idle(40, "R7");
        while (m_cnt != 0) step(0, ctl_wdata, "R7");
        step(1, word(1, 1, 4, 8'h00), "R7 write on underflow");
        idle(40, "R7");
        measure("R7 after coincident write", 5, 1);

        // R9: source and reload switch together
        step(1, word(1, 0, 7, 8'h00), "R9");
        idle(40, "R9");
        measure("R9 toggle R=7", 16, 8);

        // R8: disable
        step(1, word(0, 0, 1, 8'h00), "R8");
        idle(20, "R8");
        hi_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (fout || fout_oe) hi_cnt++;
            step(0, ctl_wdata, "R8");
        end
        chk_int("R8 disabled activity", hi_cnt, 0);

        // R8: re-enable gives the pin back
        step(1, word(1, 0, 1, 8'h00), "R8");
        idle(10, "R8");
        chk("R8 re-enabled oe", fout_oe, 1'b1);
        measure("R8 toggle R=1", 4, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule